// File: doc/BRIEF.md
# Three-Rail Power-Up Sequencer with Fault Shutdown

This block turns on a board's supply rails in a fixed order and drives the board's supervisory signals. It takes three digitised comparator results: the 3.3 V input is above 3.0 V, the 1.8 V rail is above 1.7 V, and the 2.5 V rail is above 2.375 V. It also takes a 1 kHz millisecond tick. It drives the 1.8 V regulator enable, the 2.5 V converter enable, a power-good flag and an active-low CPU reset. The comparator levels are resynchronised inside the block. The analog thresholds and any glitch filtering are handled outside the block.

The supply comes up in this order:
1. Once the 3.3 V input is good, the 1.8 V regulator is enabled.
2. Once the 1.8 V rail is good, the 2.5 V converter is enabled.
3. Once the 2.5 V rail is good, power-good goes high.
4. After a programmable number of ticks (50 by default), CPU reset is released.

CPU reset stays asserted throughout this power-up. If a rail drops while power-good is high, the block shuts down. It first asserts CPU reset, then removes both enables on the following cycle. It then stays in a stop state that only the block reset can leave.

Top module: `psu_seq_top`

## Requirements
- R1: While rst_ni is low, and just after it is released with all rail inputs low, the outputs are en18_o=0, en25_o=0, pwr_good_o=0 and cpu_rst_no=0.
- R2: en18_o goes high only once vin_ok_i is high. cpu_rst_no stays 0 while it does so.
- R3: en25_o goes high only after rail18_ok_i is high. en25_o is never high without en18_o.
- R4: pwr_good_o goes high only after rail25_ok_i is high, with both enables on.
- R5: After pwr_good_o rises, cpu_rst_no stays 0 until INIT_MS ticks of ms_tick_i have been counted. It goes to 1 on the cycle after the edge that samples the last tick.
- R6: During the initialisation wait or the running state, any of the three rail inputs going low clears pwr_good_o and drives cpu_rst_no to 0.
- R7: On shutdown, there is exactly one cycle with cpu_rst_no=0 and both enables still on. Both enables then go to 0 together.
- R8: After shutdown the outputs stay at all-zero whatever the rail and tick inputs do. Only rst_ni returns the block to waiting for the 3.3 V input.
- R9: Before power-good is reached, a rail input going low causes no shutdown, and the enables already granted stay on.
- R10: Each rail input passes through two flip-flops. A change driven between clock edges is acted on at the third rising edge after it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| ms_tick_i | input | 1 | One-cycle pulse per millisecond |
| vin_ok_i | input | 1 | 3.3 V input above 3.0 V |
| rail18_ok_i | input | 1 | 1.8 V rail above its limit |
| rail25_ok_i | input | 1 | 2.5 V rail above its limit |
| en18_o | output | 1 | 1.8 V regulator enable |
| en25_o | output | 1 | 2.5 V converter enable |
| pwr_good_o | output | 1 | All rails good |
| cpu_rst_no | output | 1 | CPU reset, active low |

## Verification
The rails are brought up one at a time, with a long hold at each step. This shows that each enable waits for its own rail and not for time passing. A rail is dropped before power-good, which separates the wait states, where no fault exit exists, from the states that are monitored. A rail is then dropped during the running state, and again during the initialisation wait with all rails raised at once. These runs tell apart the one-cycle reset-first shutdown order and the terminal stop. Ticks are counted to one short of the limit and then to the limit, which pins the reset release to the exact cycle.

// File: rtl/psu_seq_pkg.sv
package psu_seq_pkg;
  typedef enum logic [2:0] {
    ST_WAIT_VIN,
    ST_WAIT_18,
    ST_WAIT_25,
    ST_INIT,
    ST_RUN,
    ST_SHUT,
    ST_STOP
  } seq_state_e;
endpackage

// File: rtl/psu_sync.sv
module psu_sync #(
  parameter int W = 3
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] meta_q, sync_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      meta_q <= '0;
      sync_q <= '0;
    end else begin
      meta_q <= d_i;
      sync_q <= meta_q;
    end
  end

  assign q_o = sync_q;
endmodule

// File: rtl/psu_delay.sv
module psu_delay #(
  parameter int CNT = 50
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic tick_i,
  output logic done_o
);
  localparam int CW = $clog2(CNT + 1);
  localparam logic [CW-1:0] CNT_V = CW'(CNT);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                       cnt_q <= '0;
    else if (clr_i)                    cnt_q <= '0;
    else if (tick_i && cnt_q != CNT_V) cnt_q <= cnt_q + 1'b1;
  end

  assign done_o = (cnt_q == CNT_V);

  // R5: counter saturates at the limit
  assert_cnt_bound_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= CNT_V);
endmodule

// File: rtl/psu_seq_fsm.sv
module psu_seq_fsm
  import psu_seq_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic vin_ok_i,
  input  logic r18_ok_i,
  input  logic r25_ok_i,
  input  logic wait_done_i,
  output logic wait_clr_o,
  output logic en18_o,
  output logic en25_o,
  output logic pwr_good_o,
  output logic cpu_rst_no
);
  seq_state_e state_q, state_d;
  logic fault;

  assign fault = !(vin_ok_i && r18_ok_i && r25_ok_i);

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_WAIT_VIN: if (vin_ok_i) state_d = ST_WAIT_18;
      ST_WAIT_18:  if (r18_ok_i) state_d = ST_WAIT_25;
      ST_WAIT_25:  if (r25_ok_i) state_d = ST_INIT;
      ST_INIT: begin
        if (fault)            state_d = ST_SHUT;
        else if (wait_done_i) state_d = ST_RUN;
      end
      ST_RUN:  if (fault) state_d = ST_SHUT;
      ST_SHUT: state_d = ST_STOP;
      ST_STOP: state_d = ST_STOP;
      default: state_d = ST_STOP;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= ST_WAIT_VIN;
    else         state_q <= state_d;
  end

  always_comb begin
    en18_o     = 1'b0;
    en25_o     = 1'b0;
    pwr_good_o = 1'b0;
    cpu_rst_no = 1'b0;
    unique case (state_q)
      ST_WAIT_18: en18_o = 1'b1;
      ST_WAIT_25, ST_SHUT: begin
        en18_o = 1'b1;
        en25_o = 1'b1;
      end
      ST_INIT: begin
        en18_o     = 1'b1;
        en25_o     = 1'b1;
        pwr_good_o = 1'b1;
      end
      ST_RUN: begin
        en18_o     = 1'b1;
        en25_o     = 1'b1;
        pwr_good_o = 1'b1;
        cpu_rst_no = 1'b1;
      end
      default: ;
    endcase
  end

  assign wait_clr_o = (state_q != ST_INIT);

  assert_en25_needs_en18_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en25_o |-> en18_o);
  assert_pg_needs_rails_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pwr_good_o |-> (en18_o && en25_o));
  assert_rst_release_after_wait_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(cpu_rst_no) |-> $past(wait_done_i));
  assert_rst_low_on_pg_drop_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(pwr_good_o) |-> (!cpu_rst_no && en18_o && en25_o));
  assert_en_drop_after_rst_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(en25_o) |-> ($past(!cpu_rst_no) && !en18_o));
  assert_stop_sticky_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_STOP) |=> (state_q == ST_STOP));
endmodule

// File: rtl/psu_seq_top.sv
module psu_seq_top #(
  parameter int INIT_MS = 50
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic ms_tick_i,
  input  logic vin_ok_i,
  input  logic rail18_ok_i,
  input  logic rail25_ok_i,
  output logic en18_o,
  output logic en25_o,
  output logic pwr_good_o,
  output logic cpu_rst_no
);
  localparam int NRAIL = 3;

  logic [NRAIL-1:0] rail_raw, rail_s;
  logic             wait_clr, wait_done;

  assign rail_raw = {rail25_ok_i, rail18_ok_i, vin_ok_i};

  psu_sync #(.W(NRAIL)) i_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    (rail_raw),
    .q_o    (rail_s)
  );

  psu_delay #(.CNT(INIT_MS)) i_delay (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (wait_clr),
    .tick_i (ms_tick_i),
    .done_o (wait_done)
  );

  psu_seq_fsm i_fsm (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .vin_ok_i    (rail_s[0]),
    .r18_ok_i    (rail_s[1]),
    .r25_ok_i    (rail_s[2]),
    .wait_done_i (wait_done),
    .wait_clr_o  (wait_clr),
    .en18_o      (en18_o),
    .en25_o      (en25_o),
    .pwr_good_o  (pwr_good_o),
    .cpu_rst_no  (cpu_rst_no)
  );
endmodule

// File: tb/test_psu_seq_top.sv
`timescale 1ns/1ps
module test_psu_seq_top;
  localparam int INIT_MS = 4;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic ms_tick = 1'b0;
  logic vin = 1'b0, r18 = 1'b0, r25 = 1'b0;
  logic en18, en25, pg, cpu_rst_n;
  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  psu_seq_top #(.INIT_MS(INIT_MS)) i_psu_seq_top (
    .clk_i       (clk),
    .rst_ni      (rst_ni),
    .ms_tick_i   (ms_tick),
    .vin_ok_i    (vin),
    .rail18_ok_i (r18),
    .rail25_ok_i (r25),
    .en18_o      (en18),
    .en25_o      (en25),
    .pwr_good_o  (pwr_good_o_w),
    .cpu_rst_no  (cpu_rst_n)
  );
  logic pwr_good_o_w;
  assign pg = pwr_good_o_w;

  // {en18, en25, pg, cpu_rst_n}
  task automatic chk(input string req, input logic [3:0] exp);
    logic [3:0] act;
    act = {en18, en25, pg, cpu_rst_n};
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s: outputs=%b expected=%b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic tick_pulse();
    ms_tick = 1'b1;
    @(posedge clk);
    @(negedge clk);
    ms_tick = 1'b0;
  endtask

  task automatic t_reset();
    rst_ni = 1'b0; vin = 0; r18 = 0; r25 = 0;
    step(2);
    chk("R1 in reset", 4'b0000);
    rst_ni = 1'b1;
    step(3);
    chk("R1 after reset", 4'b0000);
  endtask

  task automatic t_vin_sync();
    vin = 1'b1;
    step(2);
    chk("R10 two flops no action yet", 4'b0000);
    step(1);
    chk("R2 en18 on, reset held", 4'b1000);
  endtask

  task automatic t_order();
    step(8);
    chk("R3 en25 waits for 1.8V rail", 4'b1000);
    r18 = 1'b1;
    step(3);
    chk("R3 en25 after 1.8V rail", 4'b1100);
  endtask

  task automatic t_early_drop();
    vin = 1'b0;
    step(6);
    chk("R9 no fault exit before power-good", 4'b1100);
    vin = 1'b1;
    step(4);
    chk("R9 still waiting for 2.5V", 4'b1100);
  endtask

  task automatic t_pg_and_wait();
    r25 = 1'b1;
    step(3);
    chk("R4 power-good after 2.5V rail", 4'b1110);
    for (int i = 0; i < INIT_MS - 1; i++) tick_pulse();
    step(3);
    chk("R5 reset held one tick short", 4'b1110);
    tick_pulse();
    chk("R5 not yet released on last tick edge", 4'b1110);
    step(1);
    chk("R5 reset released", 4'b1111);
  endtask

  task automatic t_fault_run();
    r18 = 1'b0;
    step(3);
    chk("R6 R7 reset first, enables still on", 4'b1100);
    step(1);
    chk("R7 both enables removed", 4'b0000);
  endtask

  task automatic t_stop();
    r18 = 1'b1;
    for (int i = 0; i < 3; i++) tick_pulse();
    step(6);
    chk("R8 stop state is terminal", 4'b0000);
    rst_ni = 1'b0; vin = 0; r18 = 0; r25 = 0;
    step(1);
    rst_ni = 1'b1;
    step(1);
    chk("R8 reset leaves stop", 4'b0000);
  endtask

  task automatic t_fault_init();
    vin = 1; r18 = 1; r25 = 1;
    step(3);
    chk("R2 en18 after vin", 4'b1000);
    step(1);
    chk("R3 en25 next", 4'b1100);
    step(1);
    chk("R4 power-good next", 4'b1110);
    tick_pulse();
    r25 = 1'b0;
    step(3);
    chk("R6 fault during init wait", 4'b1100);
    step(1);
    chk("R7 enables off after init fault", 4'b0000);
    r25 = 1'b1;
    for (int i = 0; i < INIT_MS + 2; i++) tick_pulse();
    step(4);
    chk("R8 stop holds after init fault", 4'b0000);
  endtask

  initial begin
    @(negedge clk);
    t_reset();
    t_vin_sync();
    t_order();
    t_early_drop();
    t_pg_and_wait();
    t_fault_run();
    t_stop();
    t_fault_init();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule